// File: doc/BRIEF.md
# Linked-Reservation Store Monitor

This block sits between several requesting ports and one word-addressed shared memory. It grants that memory to one requester at a time. It supports four access kinds: plain load, plain store, reserving load and conditional store. A reserving load returns the word and arms a reservation for that port on the address. A conditional store writes only if the port's reservation on that exact address is still armed. It reports 1 on success and 0 on failure. Any write to a reserved address by another port disarms that reservation, so software can build atomic read-modify-write sequences by retrying the pair until the conditional store succeeds.

Each port has one reservation: an armed bit and an address. A round-robin arbiter picks one pending request at a time. A two-state machine handles each granted request. In `ST_IDLE`, the transition *accept* fires when any request is pending: the winner's access is applied to memory and to the reservation table, and the state moves to `ST_RESP`. In `ST_RESP`, the response is presented on the winner's port for one cycle, and the transition *release* returns the state to `ST_IDLE` without condition. A requester holds its request until it sees its response pulse.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, no response is pending, every memory word reads 0 and no port holds a reservation, so a conditional store fails.
- R2: Operation codes are 0 load, 1 store, 2 reserving load and 3 conditional store. Each accepted request produces exactly one single-cycle response pulse on its own port's response line. A lone request raised while the monitor is idle is answered in the cycle after the clock edge that accepts it.
- R3: A plain store writes its data to the addressed word, and a later load returns that word.
- R4: A reserving load returns the addressed word and arms that port's reservation on the address. A following conditional store from that port to that address, with no intervening write by another port, writes the data and reports 1.
- R5: A plain store by another port to the reserved address, between the reserving load and the conditional store, makes the conditional store report 0 and leave memory unchanged.
- R6: A successful conditional store by another port to the reserved address also makes the conditional store fail. Two ports that increment a shared counter with retries both succeed, with distinct values.
- R7: Loads by other ports, reserving loads by other ports, stores by other ports to other addresses and a plain store by the reserving port itself leave a reservation armed.
- R8: A conditional store with no armed reservation, or to an address other than the reserved one, reports 0 and does not write.
- R9: A conditional store disarms its port's reservation whether it succeeds or fails, so a second conditional store without a new reserving load fails.
- R10: A new reserving load replaces the port's previous reservation.
- R11: Simultaneous requests are served one at a time in rotating order. Two simultaneous conditional stores on the same reserved address yield exactly one success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Per-port request, held until that port's response |
| req_op | input | 2*NPORTS | Per-port operation code, port p at bits [2p+1:2p] |
| req_addr | input | ADDR_W*NPORTS | Per-port word address, port p at slice p |
| req_wdata | input | DATA_W*NPORTS | Per-port write data, port p at slice p |
| rsp_valid | output | NPORTS | One-cycle response pulse on the served port |
| rsp_rdata | output | DATA_W | Word read by the served load or reserving load |
| rsp_sc_ok | output | 1 | 1 when the served conditional store succeeded |

## Verification
The bench sweeps every ordered pair of distinct ports. For each pair it places every kind of interfering access between one port's reserving load and its conditional store, and it predicts each outcome from the write rule. A monitor that ignored writes from other ports would let a stale conditional store succeed. One that cleared reservations on any access would fail after mere loads or after stores to other words. Directed cases cover a conditional store to the wrong address, a repeated conditional store, a replaced reservation and a port's own plain store. A simultaneous conditional-store race checks that a missing clear lets both racers win, and that a broken arbiter breaks the rotating service order.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } mem_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } mon_state_e;

endpackage

// File: rtl/llsc_rr_arbiter.sv
module llsc_rr_arbiter #(
    parameter int NPORTS = 3,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] req,
    input  logic              advance,
    output logic [NPORTS-1:0] gnt_oh,
    output logic [IDX_W-1:0]  gnt_idx
);

    logic [IDX_W-1:0] ptr_q;
    logic             found;
    int               cand;

    // search starting at the rotating pointer
    always_comb begin
        gnt_oh  = '0;
        gnt_idx = '0;
        found   = 1'b0;
        cand    = 0;
        for (int k = 0; k < NPORTS; k++) begin
            cand = int'(ptr_q) + k;
            if (cand >= NPORTS) cand = cand - NPORTS;
            if (!found && req[cand]) begin
                found        = 1'b1;
                gnt_oh[cand] = 1'b1;
                gnt_idx      = IDX_W'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            if (int'(gnt_idx) == NPORTS - 1) ptr_q <= '0;
            else                             ptr_q <= gnt_idx + 1'b1;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh)); // R11
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|(gnt_oh & req))); // R11

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [IDX_W-1:0]  port,
    input  mem_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    output logic              sc_pass
);

    logic [NPORTS-1:0] armed_q;
    logic [ADDR_W-1:0] addr_q [NPORTS];
    logic              writes;

    assign sc_pass = armed_q[port] && (addr_q[port] == addr);
    assign writes  = (op == OP_STORE) || ((op == OP_COND) && sc_pass);

    for (genvar i = 0; i < NPORTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q[i] <= 1'b0;
                addr_q[i]  <= '0;
            end else if (fire) begin
                if (int'(port) == i) begin
                    if (op == OP_LINK) begin
                        armed_q[i] <= 1'b1;
                        addr_q[i]  <= addr;
                    end else if (op == OP_COND) begin
                        armed_q[i] <= 1'b0;
                    end
                end else if (writes && armed_q[i] && (addr_q[i] == addr)) begin
                    armed_q[i] <= 1'b0;
                end
            end
        end

        AST_FOREIGN_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && writes && int'(port) != i && armed_q[i] && addr_q[i] == addr)
            |=> !armed_q[i]); // R5
    end

    AST_LINK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_LINK) |=> (armed_q[$past(port)] && addr_q[$past(port)] == $past(addr))); // R4
    AST_COND_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_COND) |=> !armed_q[$past(port)]); // R9

endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) words_q[w] <= '0;
            rdata <= '0;
        end else begin
            if (rd_en) rdata <= words_q[addr];
            if (wr_en) words_q[addr] <= wdata;
        end
    end

    AST_WRITE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_en); // R3

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        req_valid,
    input  logic [2*NPORTS-1:0]      req_op,
    input  logic [ADDR_W*NPORTS-1:0] req_addr,
    input  logic [DATA_W*NPORTS-1:0] req_wdata,
    output logic [NPORTS-1:0]        rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_sc_ok
);

    localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    mon_state_e        state_q, state_d;
    logic              fire;
    logic [NPORTS-1:0] gnt_oh;
    logic [IDX_W-1:0]  gnt_idx, gnt_q;
    mem_op_e           sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              sc_pass;
    logic              wr_en;
    logic              sc_ok_q;

    assign fire = (state_q == ST_IDLE) && (|req_valid);

    llsc_rr_arbiter #(.NPORTS(NPORTS), .IDX_W(IDX_W)) arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .advance (fire),
        .gnt_oh  (gnt_oh),
        .gnt_idx (gnt_idx)
    );

    // pick the winner's request fields
    always_comb begin
        sel_op    = mem_op_e'(req_op[2*gnt_idx +: 2]);
        sel_addr  = req_addr[ADDR_W*gnt_idx +: ADDR_W];
        sel_wdata = req_wdata[DATA_W*gnt_idx +: DATA_W];
    end

    llsc_resv_table #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) resv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .port    (gnt_idx),
        .op      (sel_op),
        .addr    (sel_addr),
        .sc_pass (sc_pass)
    );

    assign wr_en = fire && ((sel_op == OP_STORE) || ((sel_op == OP_COND) && sc_pass));

    llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (fire),
        .wr_en (wr_en),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (rsp_rdata)
    );

    // state register and captured response fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gnt_q   <= '0;
            sc_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                gnt_q   <= gnt_idx;
                sc_ok_q <= (sel_op == OP_COND) && sc_pass;
            end
        end
    end

    // transitions: accept (IDLE->RESP), release (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (|req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rsp_valid = '0;
        rsp_sc_ok = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                for (int i = 0; i < NPORTS; i++) rsp_valid[i] = (int'(gnt_q) == i);
                rsp_sc_ok = sc_ok_q;
            end
            default: ;
        endcase
    end

    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid)); // R2
    AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |-> $past(fire)); // R2
    AST_OK_ONLY_COND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok |-> ($past(sel_op) == OP_COND)); // R4
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_valid) |=> (rsp_valid == '0)); // R2

endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;

    localparam int NP = 3;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_valid;
    logic [2*NP-1:0]  req_op;
    logic [AW*NP-1:0] req_addr;
    logic [DW*NP-1:0] req_wdata;
    logic [NP-1:0]    rsp_valid;
    logic [DW-1:0]    rsp_rdata;
    logic             rsp_sc_ok;

    logic [NP-1:0] tb_v;
    logic [1:0]    tb_op [NP];
    logic [AW-1:0] tb_addr [NP];
    logic [DW-1:0] tb_wd [NP];

    int checks = 0;
    int failures = 0;
    int mdl [DEPTH];
    int r_data [NP];
    int r_ok [NP];
    int seq [NP];
    int nseq;
    int first_lat;

    always #2.5 clk = ~clk;

    always_comb begin
        req_valid = tb_v;
        for (int p = 0; p < NP; p++) begin
            req_op[2*p +: 2]     = tb_op[p];
            req_addr[AW*p +: AW] = tb_addr[p];
            req_wdata[DW*p +: DW] = tb_wd[p];
        end
    end

    llsc_monitor #(.NPORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok));

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_ops(input logic [NP-1:0] mask);
        logic [NP-1:0] got;
        int cyc;
        got = '0;
        nseq = 0;
        cyc = 0;
        first_lat = -1;
        @(negedge clk);
        tb_v = mask;
        while (got != mask && cyc < 40) begin
            @(negedge clk);
            cyc++;
            for (int p = 0; p < NP; p++) begin
                if (rsp_valid[p]) begin
                    if (first_lat < 0) first_lat = cyc;
                    got[p] = 1'b1;
                    r_data[p] = int'(rsp_rdata);
                    r_ok[p] = int'(rsp_sc_ok);
                    seq[nseq] = p;
                    nseq++;
                    tb_v[p] = 1'b0;
                end
            end
        end
        tb_v = '0;
        if (got != mask) check("R2", "all requests answered", int'(got), int'(mask));
    endtask

    task automatic do1(input int p, input int op, input int a, input int wd, output int d, output int ok);
        tb_op[p] = 2'(op);
        tb_addr[p] = AW'(a);
        tb_wd[p] = DW'(wd);
        run_ops(NP'(1) << p);
        check("R2", "single request latency", first_lat, 1);
        d = r_data[p];
        ok = r_ok[p];
    endtask

    task automatic expect_load(input string req, input int p, input int a);
        int d, ok;
        do1(p, 0, a, 0, d, ok);
        check(req, $sformatf("load port %0d addr %0d", p, a), d, mdl[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("R2", "watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d, ok, xa, ya, v, a, b;
        tb_v = '0;
        for (int p = 0; p < NP; p++) begin
            tb_op[p] = '0; tb_addr[p] = '0; tb_wd[p] = '0;
        end
        for (int w = 0; w < DEPTH; w++) mdl[w] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "no response after reset", int'(rsp_valid), 0);
        expect_load("R1", 1, 5);
        do1(0, 3, 5, 8'h5a, d, ok);
        check("R1", "cond store without reservation after reset", ok, 0);
        expect_load("R1", 2, 5);

        // R3 store/load over every address
        for (int w = 0; w < DEPTH; w++) begin
            do1(w % NP, 1, w, (w * 7 + 3) & 8'hff, d, ok);
            mdl[w] = (w * 7 + 3) & 8'hff;
        end
        for (int w = 0; w < DEPTH; w++) expect_load("R3", (w + 1) % NP, w);

        // R4..R8 sweep over port pairs and interfering accesses
        for (int pa = 0; pa < NP; pa++) begin
            for (int pb = 0; pb < NP; pb++) begin
                if (pa == pb) continue;
                for (int k = 0; k < 5; k++) begin
                    xa = (pa * 5 + pb * 3 + k) % DEPTH;
                    ya = (xa + 1) % DEPTH;
                    v = (pa * 40 + pb * 11 + k * 3 + 1) & 8'hff;
                    do1(pa, 2, xa, 0, d, ok);
                    check("R4", "reserving load data", d, mdl[xa]);
                    case (k)
                        0: expect_load("R7", pb, xa);
                        1: begin do1(pb, 1, xa, v ^ 8'h80, d, ok); mdl[xa] = v ^ 8'h80; end
                        2: begin do1(pb, 1, ya, v ^ 8'h40, d, ok); mdl[ya] = v ^ 8'h40; end
                        3: begin
                            do1(pb, 2, xa, 0, d, ok);
                            do1(pb, 3, xa, v ^ 8'h20, d, ok);
                            check("R6", "other port cond store succeeds", ok, 1);
                            mdl[xa] = v ^ 8'h20;
                        end
                        default: begin
                            do1(pb, 3, xa, v ^ 8'h10, d, ok);
                            check("R8", "cond store with no reservation", ok, 0);
                        end
                    endcase
                    do1(pa, 3, xa, v, d, ok);
                    if (k == 1) check("R5", "fail after foreign store", ok, 0);
                    else if (k == 3) check("R6", "fail after foreign cond store", ok, 0);
                    else check("R7", $sformatf("reservation survives case %0d", k), ok, 1);
                    if (ok == 1) mdl[xa] = v;
                    expect_load("R5", pb, xa);
                end
            end
        end

        // R7 own plain store keeps reservation
        do1(0, 2, 3, 0, d, ok);
        do1(0, 1, 3, 8'h33, d, ok); mdl[3] = 8'h33;
        do1(0, 3, 3, 8'h34, d, ok);
        check("R7", "own store keeps reservation", ok, 1);
        mdl[3] = 8'h34;
        expect_load("R7", 1, 3);

        // R8 wrong address
        do1(1, 2, 6, 0, d, ok);
        do1(1, 3, 7, 8'h77, d, ok);
        check("R8", "cond store to other address", ok, 0);
        expect_load("R8", 2, 7);

        // R9 consumption
        do1(2, 2, 8, 0, d, ok);
        do1(2, 3, 8, 8'h81, d, ok);
        check("R9", "first cond store", ok, 1);
        mdl[8] = 8'h81;
        do1(2, 3, 8, 8'h82, d, ok);
        check("R9", "second cond store", ok, 0);
        expect_load("R9", 0, 8);

        // R10 replacement
        do1(0, 2, 10, 0, d, ok);
        do1(0, 2, 11, 0, d, ok);
        do1(0, 3, 10, 8'ha0, d, ok);
        check("R10", "old reservation replaced", ok, 0);
        do1(0, 2, 10, 0, d, ok);
        do1(0, 2, 11, 0, d, ok);
        do1(0, 3, 11, 8'hb1, d, ok);
        check("R10", "new reservation used", ok, 1);
        mdl[11] = 8'hb1;
        expect_load("R10", 1, 10);
        expect_load("R10", 1, 11);

        // R11 rotating service of three simultaneous loads
        for (int p = 0; p < NP; p++) begin
            tb_op[p] = 2'd0; tb_addr[p] = AW'(p + 1);
        end
        run_ops(3'b111);
        check("R11", "three responses", nseq, 3);
        check("R11", "rotation 1", seq[1], (seq[0] + 1) % NP);
        check("R11", "rotation 2", seq[2], (seq[1] + 1) % NP);
        for (int p = 0; p < NP; p++) check("R11", "simultaneous load data", r_data[p], mdl[p + 1]);

        // R11 simultaneous conditional store race
        do1(0, 2, 12, 0, d, ok);
        do1(1, 2, 12, 0, d, ok);
        tb_op[0] = 2'd3; tb_addr[0] = 4'd12; tb_wd[0] = 8'h11;
        tb_op[1] = 2'd3; tb_addr[1] = 4'd12; tb_wd[1] = 8'h22;
        run_ops(3'b011);
        check("R11", "exactly one racer wins", r_ok[0] + r_ok[1], 1);
        if (r_ok[0] == 1) mdl[12] = 8'h11;
        else if (r_ok[1] == 1) mdl[12] = 8'h22;
        expect_load("R11", 2, 12);

        // R6 counter with retries by two ports
        do1(0, 2, 9, 0, a, ok);
        do1(1, 2, 9, 0, b, ok);
        do1(0, 3, 9, (a + 1) & 8'hff, d, ok);
        check("R6", "first incrementer wins", ok, 1);
        do1(1, 3, 9, (b + 1) & 8'hff, d, ok);
        check("R6", "second incrementer fails", ok, 0);
        do1(1, 2, 9, 0, b, ok);
        check("R6", "retry sees new count", b, (a + 1) & 8'hff);
        do1(1, 3, 9, (b + 1) & 8'hff, d, ok);
        check("R6", "retry succeeds", ok, 1);
        mdl[9] = (a + 2) & 8'hff;
        expect_load("R6", 2, 9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule